// File: doc/BRIEF.md
# I2C Interrupt Status Flags

This block keeps the read-only interrupt status byte of an I2C master/slave controller and produces that controller's interrupt request. The protocol engine, the shift register and the address comparator sit outside it. They report what happens on the bus through single-cycle event strobes and level indications. The CPU side supplies three one-cycle access strobes: a data-register read, a data-register write and a status-register read. Each flag has its own set event and its own clear-by-access side effect. When a set and a clear fall in the same cycle, the set takes priority, so no event is lost.

The interrupt line is registered and follows the flags one clock later. The transmit-empty flag requests an interrupt only when the core is not busy shifting. It is held back while a received byte is shifting in, and while an address byte with the read direction is shifting. Clearing the controller enable returns the whole byte to its reset value and silences the interrupt.

Top module: `i2c_istat_flags`

## Requirements
- R1: The status word packs, from bit 7 down to bit 0: tx-empty, rx-full, address-hit, general-call, read-direction, arbitration-lost, stop-seen, nack-seen.
- R2: After reset the status word is 8'h80 and irq is 0.
- R3: While ctl_en is 0, at every clock the status word returns to 8'h80 and irq to 0, and all event strobes are ignored.
- R4: Tx-empty (bit 7) clears one cycle after cpu_data_wr and sets one cycle after ev_tx_load. If both occur in the same cycle, it ends set.
- R5: Rx-full (bit 6) sets one cycle after ev_rx_byte and clears one cycle after cpu_data_rd. If both occur in the same cycle, it ends set.
- R6: Address-hit (bit 5) sets one cycle after ev_addr_match and clears one cycle after cpu_stat_rd. Set wins over clear.
- R7: On ev_addr_done, bit 4 loads addr_gen_call and bit 3 loads addr_dir. Otherwise both bits hold. Neither bit ever requests an interrupt.
- R8: Bits 2, 1 and 0 set one cycle after ev_arb_lost, ev_stop and ev_nack respectively. Each clears one cycle after cpu_stat_rd. Set wins over clear.
- R9: irq is high one cycle after a cycle in which ctl_en is 1 and any of bits 7, 6, 5, 2, 1 or 0 requests; otherwise it is low.
- R10: Bit 7 does not request an interrupt in a cycle where rx_shifting is 1, or where addr_shifting and addr_dir are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Controller enable |
| ev_tx_load | input | 1 | Core took the data byte for transmission (strobe) |
| ev_rx_byte | input | 1 | Core completed receiving a byte (strobe) |
| ev_addr_match | input | 1 | Slave address matched (strobe) |
| ev_addr_done | input | 1 | First address byte of a transaction finished (strobe) |
| addr_gen_call | input | 1 | General call or start byte recognised, sampled on ev_addr_done |
| addr_dir | input | 1 | Direction bit of the current address byte, 1 means read |
| ev_arb_lost | input | 1 | Arbitration lost (strobe) |
| ev_stop | input | 1 | Stop condition seen (strobe) |
| ev_nack | input | 1 | Not-acknowledge seen (strobe) |
| rx_shifting | input | 1 | A received byte is being shifted in |
| addr_shifting | input | 1 | An address byte is being shifted |
| cpu_data_rd | input | 1 | CPU read of the data register (strobe) |
| cpu_data_wr | input | 1 | CPU write of the data register (strobe) |
| cpu_stat_rd | input | 1 | CPU read of the status register (strobe) |
| status | output | 8 | Packed status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event and access strobes are synchronous to clk and each last one cycle per occurrence. They also assume that addr_dir is valid whenever addr_shifting or ev_addr_done is high. Beyond that, any combination of strobes in one cycle is legal, including a set event together with its own clear access. The stimulus keeps to these rules: directed sequences are followed by random cycles in which every strobe is drawn independently each cycle and ctl_en drops occasionally. This makes set/clear collisions, masked transmit-empty requests and disable in mid-activity all occur.

// File: rtl/istat_pkg.sv
// Package: shared constants for the I2C interrupt status flag logic.
// Assumes: sticky flags are indexed 0..NUM_FLAGS-1 in the order below.
package istat_pkg;
    localparam int NUM_FLAGS = 6;
    localparam int STAT_W    = 8;

    // Sticky flag indices (set by event, cleared by access)
    localparam int FL_NACK = 0;
    localparam int FL_STOP = 1;
    localparam int FL_ARB  = 2;
    localparam int FL_SAM  = 3;
    localparam int FL_RXF  = 4;
    localparam int FL_TXE  = 5;

    // Reset value of each sticky flag; only tx-empty comes up set
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'b100000;

    // Reset value of the packed status word
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

    typedef struct packed {
        logic gca;
        logic rd;
    } dir_info_t;
endpackage

// File: rtl/istat_flag_cell.sv
// Module: one sticky status flag with a set event and a clear access.
// Assumes: set has priority over clear; a disabled controller reloads RST_VAL.
module istat_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register: reset/disable value, then set-over-clear update
    always_ff @(posedge clk) begin
        if (!rst_n || !en) q <= RST_VAL;
        else if (set)      q <= 1'b1;
        else if (clr)      q <= 1'b0;
    end
endmodule

// File: rtl/istat_dir_capture.sv
// Module: captures general-call and direction status at the end of the
// first address byte of each transaction.
// Assumes: the inputs are valid in the cycle ev_addr_done is high.
module istat_dir_capture
    import istat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      ev_addr_done,
    input  logic      addr_gen_call,
    input  logic      addr_dir,
    output dir_info_t info
);
    // Capture register: cleared while disabled, loaded on address completion
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            info <= '0;
        end else if (ev_addr_done) begin
            info.gca <= addr_gen_call;
            info.rd  <= addr_dir;
        end
    end
endmodule

// File: rtl/istat_irq_gen.sv
// Module: registered interrupt request from the sticky flags.
// Assumes: mask_txe suppresses only the tx-empty request in its cycle.
module istat_irq_gen
    import istat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 mask_txe,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] req_v;

    // Request vector: every sticky flag requests, tx-empty only when unmasked
    always_comb begin
        req_v          = flags;
        req_v[FL_TXE]  = flags[FL_TXE] & ~mask_txe;
    end

    // Interrupt register: low while disabled, else OR of requests
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= en & (|req_v);
    end
endmodule

// File: rtl/i2c_istat_flags.sv
// Module: I2C interrupt status byte and interrupt request.
// Assumes: all event and access inputs are single-cycle strobes, synchronous
// to clk; addr_dir is valid while an address is shifting or completing.
module i2c_istat_flags
    import istat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              ev_tx_load,
    input  logic              ev_rx_byte,
    input  logic              ev_addr_match,
    input  logic              ev_addr_done,
    input  logic              addr_gen_call,
    input  logic              addr_dir,
    input  logic              ev_arb_lost,
    input  logic              ev_stop,
    input  logic              ev_nack,
    input  logic              rx_shifting,
    input  logic              addr_shifting,
    input  logic              cpu_data_rd,
    input  logic              cpu_data_wr,
    input  logic              cpu_stat_rd,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] flag_q;
    dir_info_t            dinfo;
    logic                 mask_txe;

    // Event routing: each flag's set source
    always_comb begin
        set_v          = '0;
        set_v[FL_NACK] = ev_nack;
        set_v[FL_STOP] = ev_stop;
        set_v[FL_ARB]  = ev_arb_lost;
        set_v[FL_SAM]  = ev_addr_match;
        set_v[FL_RXF]  = ev_rx_byte;
        set_v[FL_TXE]  = ev_tx_load;
    end

    // Access routing: each flag's clear-by-access side effect
    always_comb begin
        clr_v          = '0;
        clr_v[FL_NACK] = cpu_stat_rd;
        clr_v[FL_STOP] = cpu_stat_rd;
        clr_v[FL_ARB]  = cpu_stat_rd;
        clr_v[FL_SAM]  = cpu_stat_rd;
        clr_v[FL_RXF]  = cpu_data_rd;
        clr_v[FL_TXE]  = cpu_data_wr;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            istat_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (ctl_en),
                .set   (set_v[i]),
                .clr   (clr_v[i]),
                .q     (flag_q[i])
            );
        end
    endgenerate

    istat_dir_capture u_dir (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (ctl_en),
        .ev_addr_done  (ev_addr_done),
        .addr_gen_call (addr_gen_call),
        .addr_dir      (addr_dir),
        .info          (dinfo)
    );

    // Tx-empty mask: core busy receiving, or shifting a read-direction address
    always_comb mask_txe = rx_shifting | (addr_shifting & addr_dir);

    istat_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl_en),
        .flags    (flag_q),
        .mask_txe (mask_txe),
        .irq      (irq)
    );

    // Status packing: fixed bit layout seen by software
    always_comb status = {flag_q[FL_TXE], flag_q[FL_RXF], flag_q[FL_SAM],
                          dinfo.gca, dinfo.rd,
                          flag_q[FL_ARB], flag_q[FL_STOP], flag_q[FL_NACK]};
endmodule

// File: rtl/istat_flags_chk.sv
// Checker: temporal properties of the status flags, bound to the top module.
module istat_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_en,
    input logic       ev_tx_load,
    input logic       ev_rx_byte,
    input logic       ev_addr_match,
    input logic       ev_arb_lost,
    input logic       rx_shifting,
    input logic       cpu_data_wr,
    input logic       cpu_stat_rd,
    input logic [7:0] status,
    input logic       irq
);
    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (status == 8'h80) && !irq);

    // R4
    txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en && cpu_data_wr && !ev_tx_load |=> !status[7]);

    // R5
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en && ev_rx_byte |=> status[6]);

    // R6
    sam_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en && cpu_stat_rd && !ev_addr_match |=> !status[5]);

    // R8
    arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en && ev_arb_lost |=> status[2]);

    // R7
    dir_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & 8'hE7) == 8'h00) |=> !irq);

    // R10
    txe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_shifting && ((status & 8'h67) == 8'h00) |=> !irq);
endmodule

bind i2c_istat_flags istat_flags_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_en        (ctl_en),
    .ev_tx_load    (ev_tx_load),
    .ev_rx_byte    (ev_rx_byte),
    .ev_addr_match (ev_addr_match),
    .ev_arb_lost   (ev_arb_lost),
    .rx_shifting   (rx_shifting),
    .cpu_data_wr   (cpu_data_wr),
    .cpu_stat_rd   (cpu_stat_rd),
    .status        (status),
    .irq           (irq)
);

// File: tb/sim_i2c_istat_flags.sv
module sim_i2c_istat_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 1'b0;
    logic ev_tx_load = 0, ev_rx_byte = 0, ev_addr_match = 0, ev_addr_done = 0;
    logic addr_gen_call = 0, addr_dir = 0, ev_arb_lost = 0, ev_stop = 0, ev_nack = 0;
    logic rx_shifting = 0, addr_shifting = 0;
    logic cpu_data_rd = 0, cpu_data_wr = 0, cpu_stat_rd = 0;
    logic [7:0] status;
    logic irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    i2c_istat_flags u0 (.*);

    // Behavioural reference: one bit per named flag, plus expected irq
    bit m_txe, m_rxf, m_sam, m_gca, m_rd, m_arb, m_stp, m_nak, m_irq;
    always @(posedge clk) begin
        int want;
        want = 0;
        if (ctl_en) begin
            if (m_txe && !(rx_shifting || (addr_shifting && addr_dir))) want = 1;
            if (m_rxf || m_sam || m_arb || m_stp || m_nak) want = 1;
        end
        if (!rst_n) m_irq <= 0; else m_irq <= (want != 0);
        if (!rst_n || !ctl_en) begin
            m_txe <= 1; m_rxf <= 0; m_sam <= 0; m_gca <= 0; m_rd <= 0;
            m_arb <= 0; m_stp <= 0; m_nak <= 0;
        end else begin
            m_txe <= ev_tx_load    ? 1 : (cpu_data_wr ? 0 : m_txe);
            m_rxf <= ev_rx_byte    ? 1 : (cpu_data_rd ? 0 : m_rxf);
            m_sam <= ev_addr_match ? 1 : (cpu_stat_rd ? 0 : m_sam);
            m_arb <= ev_arb_lost   ? 1 : (cpu_stat_rd ? 0 : m_arb);
            m_stp <= ev_stop       ? 1 : (cpu_stat_rd ? 0 : m_stp);
            m_nak <= ev_nack       ? 1 : (cpu_stat_rd ? 0 : m_nak);
            if (ev_addr_done) begin m_gca <= addr_gen_call; m_rd <= addr_dir; end
        end
    end

    function automatic logic [7:0] model_word();
        return {m_txe, m_rxf, m_sam, m_gca, m_rd, m_arb, m_stp, m_nak};
    endfunction

    // Per-cycle comparison; each mismatching bit names its requirement
    task automatic compare_all();
        string tags [8] = '{"R8", "R8", "R8", "R7", "R7", "R6", "R5", "R4"};
        logic [7:0] exp_w;
        exp_w = model_word();
        n_cmp += 2;
        if (status !== exp_w) begin
            n_bad++;
            for (int b = 0; b < 8; b++)
                if (status[b] !== exp_w[b])
                    $display("FAIL %s: status bit %0d got %b expected %b (word %h vs %h) t=%0t",
                             tags[b], b, status[b], exp_w[b], status, exp_w, $time);
        end
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R9: irq got %b expected %b t=%0t", irq, m_irq, $time);
        end
    endtask

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {irq,status} got %h expected %h t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        {ev_tx_load, ev_rx_byte, ev_addr_match, ev_addr_done, ev_arb_lost,
         ev_stop, ev_nack, cpu_data_rd, cpu_data_wr, cpu_stat_rd} = '0;
    endtask

    initial begin
        repeat (3) tick();
        check("R2", {irq, status}, 9'h080);
        rst_n = 1; ctl_en = 1;
        tick();                               // flags update, irq registered next
        tick();
        check("R9", {irq, status}, 9'h180);   // tx-empty alone requests
        cpu_data_wr = 1; tick();              // R4 clear
        check("R4", {1'b0, status}, 9'h000);
        ev_tx_load = 1; tick();               // R4 set
        cpu_data_wr = 1; ev_tx_load = 1; tick();
        check("R4", {1'b0, status}, 9'h080);  // set wins
        ev_rx_byte = 1; tick();
        check("R5", {1'b0, status}, 9'h0C0);
        ev_rx_byte = 1; cpu_data_rd = 1; tick();
        check("R5", {1'b0, status}, 9'h0C0);
        cpu_data_rd = 1; tick();
        ev_addr_match = 1; ev_addr_done = 1; addr_gen_call = 1; addr_dir = 1; tick();
        check("R6", {1'b0, status}, 9'h0B8);
        addr_gen_call = 0; addr_dir = 0;
        ev_nack = 1; tick();
        check("R1", {1'b0, status}, 9'h0B9);
        ev_stop = 1; ev_arb_lost = 1; cpu_stat_rd = 1; tick();
        check("R8", {1'b0, status}, 9'h09E);  // stop/arb set win, sam/nack cleared
        cpu_stat_rd = 1; tick();
        check("R7", {1'b0, status}, 9'h098);  // gca/rd survive status read
        ev_addr_done = 1; addr_dir = 0; addr_gen_call = 0; tick();
        tick();
        check("R9", {irq, status}, 9'h180);
        rx_shifting = 1; tick(); tick();
        check("R10", {irq, status}, 9'h080);
        rx_shifting = 0; addr_shifting = 1; addr_dir = 1; tick(); tick();
        check("R10", {irq, status}, 9'h080);
        addr_dir = 0; tick(); tick();
        check("R10", {irq, status}, 9'h180);
        addr_shifting = 0;
        cpu_data_wr = 1; ev_addr_done = 1; addr_dir = 1; addr_gen_call = 1; tick();
        tick(); tick();
        check("R7", {irq, status}, 9'h018);   // gca/rd set, no request
        ctl_en = 0; ev_nack = 1; ev_rx_byte = 1; ev_addr_match = 1; tick();
        tick();
        check("R3", {irq, status}, 9'h080);
        ctl_en = 1;
        for (int k = 0; k < 4000; k++) begin
            ctl_en        = ($urandom_range(0, 99) != 0);
            ev_tx_load    = ($urandom_range(0, 7) == 0);
            ev_rx_byte    = ($urandom_range(0, 7) == 0);
            ev_addr_match = ($urandom_range(0, 9) == 0);
            ev_addr_done  = ($urandom_range(0, 9) == 0);
            addr_gen_call = $urandom_range(0, 1);
            addr_dir      = $urandom_range(0, 1);
            ev_arb_lost   = ($urandom_range(0, 15) == 0);
            ev_stop       = ($urandom_range(0, 15) == 0);
            ev_nack       = ($urandom_range(0, 15) == 0);
            rx_shifting   = ($urandom_range(0, 3) == 0);
            addr_shifting = ($urandom_range(0, 3) == 0);
            cpu_data_rd   = ($urandom_range(0, 5) == 0);
            cpu_data_wr   = ($urandom_range(0, 5) == 0);
            cpu_stat_rd   = ($urandom_range(0, 5) == 0);
            tick();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule